// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a three-wire serial EEPROM. The pins are chip-select, serial clock and data-in, plus an organization select. The output is a data-out signal with a separate drive enable, so the chip pad can tri-state it. The storage holds 2 Kbit, organized either as 128 words of 16 bits or as 256 bytes. The organization input picks between the two at run time, and it changes both the address length and the data length of every instruction.

All four pins are oversampled by a faster system clock. Each instruction opens with a start bit, followed by a two-bit opcode, an address field and, for some instructions, a data field. The block supports:
- reads that keep streaming while the clock runs;
- single-location writes and erases;
- array-wide writes and erases;
- a write-protect latch with enable and disable commands.

Every programming instruction is held pending until chip-select is released. A self-timed program cycle then runs. If the host reselects the part during that cycle, data-out reports busy or ready.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the data-out enable is low, every location reads as all ones, and writing is disabled.
- R2: In 16-bit mode (`org_wide` high) the address field is 8 bits, sent MSB first. Its top bit is ignored for single-location access. A read drives one zero bit after the last address bit, then the 16-bit word MSB first, one bit per serial-clock rising edge.
- R3: If the clock keeps running after a read word, the next address follows directly with no zero bit. The address wraps from the last location to 0.
- R4: In 8-bit mode (`org_wide` low) the address field is 9 bits, its top bit ignored, and data words are 8 bits. Byte address b maps to word b/2: even b to bits 7:0, odd b to bits 15:8. Sequential reads wrap from byte 255 to byte 0.
- R5: Opcode 01 followed by a data word writes that word. Programming begins only when chip-select falls after the full data word has been received.
- R6: Opcode 11 erases one location to all ones.
- R7: Opcode 00 with top field bits 01 writes one data word to every location. Opcode 00 with top field bits 10 sets every location to all ones.
- R8: Opcode 00 with top field bits 11 enables writing, and with top field bits 00 disables it. While writing is disabled, write-type instructions change nothing and start no program cycle.
- R9: While a program cycle runs and chip-select is high, data-out is driven low. Once the cycle has ended it is driven high until chip-select falls. With chip-select low the enable is off.
- R10: Instructions shifted in during a program cycle are ignored.
- R11: Dropping chip-select before an instruction is complete discards it and leaves memory unchanged.
- R12: The data-out enable is low while instruction bits are being shifted in and whenever chip-select is low.
- R13: A program cycle lasts exactly `PROG_CYCLES` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pin | input | 1 | Chip-select, active high |
| sck_pin | input | 1 | Serial clock; data-in sampled on its rising edge |
| din_pin | input | 1 | Serial data in |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| dout_val | output | 1 | Serial data out value |
| dout_oe | output | 1 | Drive enable for data out (low means high impedance) |

## Verification
The bench keeps the default 128 x 16 geometry, so wrap-around at word 127 and at byte 255 are both reached with short sequential reads. `PROG_CYCLES` is set to 300. That is long enough to shift a complete second instruction into the block while a program cycle is still running, which is how R10 is exercised. It is also short enough for dozens of programming operations to fit in the run. The exact program length is measured from the chip-select fall to the first ready level.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_ARM, ST_BUSY, ST_RDY, ST_RD, ST_DONE
  } tw_state_e;

  localparam logic [1:0] OP_EXT = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_ER  = 2'b11;

  localparam logic [1:0] EXT_WDIS = 2'b00;
  localparam logic [1:0] EXT_WALL = 2'b01;
  localparam logic [1:0] EXT_EALL = 2'b10;
  localparam logic [1:0] EXT_WEN  = 2'b11;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] now_s,
  output logic [N-1:0] prev_s
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_s  <= '0;
      prev_s <= '0;
    end else begin
      meta_q <= pins;
      now_s  <= meta_q;
      prev_s <= now_s;
    end
  end
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;

  assign done = busy && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start && !busy) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/tw_word_store.sv
module tw_word_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wide,
  input  logic                          we,
  input  logic                          wr_all,
  input  logic [$clog2(WORDS):0]        wr_idx,
  input  logic [WORD_W-1:0]             wdata,
  input  logic [$clog2(WORDS):0]        rd_idx,
  output logic [WORD_W-1:0]             rd_data
);
  localparam int IW   = $clog2(WORDS);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  hit;
  logic              be_lo, be_hi;
  logic [HALF-1:0]   wv_hi;
  logic [WORD_W-1:0] rword;

  assign be_lo = wide | wr_all | ~wr_idx[0];
  assign be_hi = wide | wr_all |  wr_idx[0];
  assign wv_hi = wide ? wdata[WORD_W-1:HALF] : wdata[HALF-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_hit
    assign hit[w] = we & (wr_all |
                    (wide ? (wr_idx[IW-1:0] == IW'(w)) : (wr_idx[IW:1] == IW'(w))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (hit[w] && be_lo) mem[w][HALF-1:0]      <= wdata[HALF-1:0];
        if (hit[w] && be_hi) mem[w][WORD_W-1:HALF] <= wv_hi;
      end
    end
  end

  assign rword = wide ? mem[rd_idx[IW-1:0]] : mem[rd_idx[IW:1]];
  assign rd_data = wide ? rword
                 : (rd_idx[0] ? {rword[WORD_W-1:HALF], {HALF{1'b0}}}
                              : {rword[HALF-1:0], {HALF{1'b0}}});
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int WORDS       = 128,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin,
  input  logic sck_pin,
  input  logic din_pin,
  input  logic org_wide,
  output logic dout_val,
  output logic dout_oe
);
  localparam int IW     = $clog2(WORDS);
  localparam int BW     = IW + 1;
  localparam int FW_WID = IW + 1;
  localparam int FW_NAR = IW + 2;
  localparam int HALF   = WORD_W / 2;
  localparam int CW     = $clog2(WORD_W + FW_NAR + 1);

  logic [3:0] pin_now, pin_prev;
  logic       cs_sync, sck_rise, din_s, wide;

  tw_pin_sync #(.N(4)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .pins({org_wide, din_pin, sck_pin, cs_pin}),
    .now_s(pin_now), .prev_s(pin_prev)
  );

  assign cs_sync  = pin_now[0];
  assign sck_rise = pin_now[1] & ~pin_prev[1];
  assign din_s    = pin_now[2];
  assign wide     = pin_now[3];

  tw_state_e          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [1:0]         op_q, op_d;
  logic [FW_NAR-1:0]  fld_q, fld_d, fld_new;
  logic [WORD_W-1:0]  dsh_q, dsh_d, dsh_new;
  logic [BW-1:0]      ptr_q, ptr_d, ptr_inc, new_idx, rd_idx;
  logic [BW-1:0]      pidx_q, pidx_d;
  logic [WORD_W-1:0]  pdat_q, pdat_d, rd_data;
  logic               wen_q, wen_d, pall_q, pall_d;
  logic               dout_q, dout_d, oe_q, oe_d;
  logic               fld_last, dat_last, prog_start, tmr_busy, tmr_done, mem_we;
  logic [1:0]         ext_code;

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(tmr_busy), .done(tmr_done)
  );

  assign mem_we = tmr_done;

  tw_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) store_i (
    .clk(clk), .rst_n(rst_n), .wide(wide), .we(mem_we), .wr_all(pall_q),
    .wr_idx(pidx_q), .wdata(pdat_q), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign fld_new  = {fld_q[FW_NAR-2:0], din_s};
  assign dsh_new  = {dsh_q[WORD_W-2:0], din_s};
  assign fld_last = wide ? (cnt_q == CW'(FW_WID - 1)) : (cnt_q == CW'(FW_NAR - 1));
  assign dat_last = wide ? (cnt_q == CW'(WORD_W - 1)) : (cnt_q == CW'(HALF - 1));
  assign ext_code = wide ? fld_new[FW_WID-1 -: 2] : fld_new[FW_NAR-1 -: 2];
  assign new_idx  = wide ? {1'b0, fld_new[IW-1:0]} : fld_new[BW-1:0];
  assign ptr_inc  = wide ? {1'b0, ptr_q[IW-1:0] + 1'b1} : ptr_q + 1'b1;
  assign rd_idx   = (st_q == ST_ADR) ? new_idx : ptr_inc;
  assign prog_start = (st_q == ST_ARM) && !cs_sync;

  always_comb begin
    st_d   = st_q;   cnt_d  = cnt_q;  op_d   = op_q;   fld_d  = fld_q;
    dsh_d  = dsh_q;  ptr_d  = ptr_q;  pidx_d = pidx_q; pdat_d = pdat_q;
    wen_d  = wen_q;  pall_d = pall_q; dout_d = dout_q;
    unique case (st_q)
      ST_IDLE: if (cs_sync && sck_rise && din_s) begin
        st_d = ST_OPC; cnt_d = '0;
      end
      ST_OPC: if (!cs_sync) st_d = ST_IDLE;
        else if (sck_rise) begin
          op_d = {op_q[0], din_s};
          if (cnt_q == CW'(1)) begin st_d = ST_ADR; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
      ST_ADR: if (!cs_sync) st_d = ST_IDLE;
        else if (sck_rise) begin
          fld_d = fld_new;
          cnt_d = fld_last ? '0 : cnt_q + 1'b1;
          if (fld_last) begin
            unique case (op_q)
              OP_RD: begin st_d = ST_RD; ptr_d = new_idx; dsh_d = rd_data; dout_d = 1'b0; end
              OP_WR: begin pidx_d = new_idx; pall_d = 1'b0; st_d = wen_q ? ST_DAT : ST_DONE; end
              OP_ER: begin pidx_d = new_idx; pall_d = 1'b0; pdat_d = '1;
                           st_d = wen_q ? ST_ARM : ST_DONE; end
              default: unique case (ext_code)
                EXT_WEN:  begin wen_d = 1'b1; st_d = ST_DONE; end
                EXT_WDIS: begin wen_d = 1'b0; st_d = ST_DONE; end
                EXT_EALL: begin pall_d = 1'b1; pdat_d = '1; st_d = wen_q ? ST_ARM : ST_DONE; end
                default:  begin pall_d = 1'b1; st_d = wen_q ? ST_DAT : ST_DONE; end
              endcase
            endcase
          end
        end
      ST_DAT: if (!cs_sync) st_d = ST_IDLE;
        else if (sck_rise) begin
          dsh_d = dsh_new;
          if (dat_last) begin pdat_d = dsh_new; st_d = ST_ARM; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
      ST_ARM:  if (!cs_sync) st_d = ST_BUSY;
      ST_BUSY: if (tmr_done) st_d = cs_sync ? ST_RDY : ST_IDLE;
      ST_RDY:  if (!cs_sync) st_d = ST_IDLE;
      ST_RD: if (!cs_sync) st_d = ST_IDLE;
        else if (sck_rise) begin
          dout_d = dsh_q[WORD_W-1];
          if (dat_last) begin ptr_d = ptr_inc; dsh_d = rd_data; cnt_d = '0; end
          else begin dsh_d = {dsh_q[WORD_W-2:0], 1'b0}; cnt_d = cnt_q + 1'b1; end
        end
      default: if (!cs_sync) st_d = ST_IDLE;
    endcase
    if (st_d == ST_BUSY) dout_d = 1'b0;
    if (st_d == ST_RDY)  dout_d = 1'b1;
    oe_d = cs_sync && (st_d == ST_RD || st_d == ST_BUSY || st_d == ST_RDY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; fld_q <= '0; dsh_q <= '0;
      ptr_q <= '0; pidx_q <= '0; pdat_q <= '0; wen_q <= 1'b0; pall_q <= 1'b0;
      dout_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; op_q <= op_d; fld_q <= fld_d; dsh_q <= dsh_d;
      ptr_q <= ptr_d; pidx_q <= pidx_d; pdat_q <= pdat_d; wen_q <= wen_d; pall_q <= pall_d;
      dout_q <= dout_d; oe_q <= oe_d;
    end
  end

  assign dout_val = dout_q;
  assign dout_oe  = oe_q;
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
  parameter int PROG_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_sync,
  input logic dout_oe,
  input logic dout_val,
  input logic tmr_busy,
  input logic prog_start,
  input logic mem_we,
  input logic wen_q
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (prog_start && !tmr_busy) run_len <= '0;
    else if (tmr_busy)  run_len <= run_len + 1;
  end

  assert_oe_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sync |=> !dout_oe);

  assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |-> !mem_we);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !prog_start);

  assert_busy_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy && $past(tmr_busy) && dout_oe) |-> !dout_val);

  assert_prog_len_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_busy) |-> (run_len == PROG_CYCLES));
endmodule

bind tw_eeprom_slave tw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .dout_oe(dout_oe),
  .dout_val(dout_val), .tmr_busy(tmr_busy), .prog_start(prog_start),
  .mem_we(mem_we), .wen_q(wen_q)
);

// File: tb/tw_eeprom_slave_tb_top.sv
module tw_eeprom_slave_tb_top;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n, cs, sck, din, org;
  logic dout_val, dout_oe;
  int   nvec = 0, nerr = 0;
  logic [15:0] ref16 [128];
  bit   wen_ref;

  always #2 clk = ~clk;

  tw_eeprom_slave #(.WORDS(128), .WORD_W(16), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_pin(cs), .sck_pin(sck), .din_pin(din),
    .org_wide(org), .dout_val(dout_val), .dout_oe(dout_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int span();
    return org ? 128 : 256;
  endfunction

  function automatic logic [15:0] model_rd(input int b);
    int x;
    x = b % span();
    if (org) return ref16[x];
    return x[0] ? {8'h00, ref16[x/2][15:8]} : {8'h00, ref16[x/2][7:0]};
  endfunction

  task automatic model_wr(input int b, input logic [15:0] d, input bit all);
    int x;
    if (all) begin
      for (int w = 0; w < 128; w++) ref16[w] = org ? d : {d[7:0], d[7:0]};
    end else if (org) ref16[b % 128] = d;
    else begin
      x = b % 256;
      if (x[0]) ref16[x/2][15:8] = d[7:0];
      else      ref16[x/2][7:0]  = d[7:0];
    end
  endtask

  function automatic logic [8:0] mk_field(input int b);
    logic [8:0] f;
    f = 9'($urandom);
    if (org) f[6:0] = b[6:0];
    else     f[7:0] = b[7:0];
    return f;
  endfunction

  function automatic logic [8:0] mk_ext(input logic [1:0] c);
    logic [8:0] f;
    f = 9'($urandom);
    if (org) f[7:6] = c;
    else     f[8:7] = c;
    return f;
  endfunction

  task automatic sk_pulse(input logic d);
    din = d; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1; tick(4);
  endtask

  task automatic cs_dn();
    cs = 1'b0; din = 1'b0; tick(6);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [8:0] f);
    int fw;
    fw = org ? 8 : 9;
    sk_pulse(1'b1); sk_pulse(op[1]); sk_pulse(op[0]);
    for (int i = fw - 1; i >= 0; i--) sk_pulse(f[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    for (int i = (org ? 15 : 7); i >= 0; i--) sk_pulse(d[i]);
  endtask

  task automatic read_words(input int b, input int n, input string tag);
    logic [15:0] v;
    cs_up();
    send_cmd(2'b10, mk_field(b));
    chk(dout_oe && !dout_val, tag, {30'd0, dout_oe, dout_val}, 32'h2);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < (org ? 16 : 8); i++) begin
        sk_pulse(1'b0);
        v = {v[14:0], dout_val};
      end
      chk(v == model_rd(b + k), tag, {16'd0, v}, {16'd0, model_rd(b + k)});
    end
    cs_dn();
    chk(!dout_oe, "R12", {31'd0, dout_oe}, 32'd0);
  endtask

  task automatic set_wen(input bit en);
    cs_up();
    send_cmd(2'b00, mk_ext(en ? 2'b11 : 2'b00));
    cs_dn();
    wen_ref = en;
  endtask

  task automatic prog_op(input logic [1:0] op, input logic [8:0] f, input int b,
                         input logic [15:0] d, input bit all, input bit has_d, input string tag);
    bit act;
    act = wen_ref;
    cs_up();
    send_cmd(op, f);
    if (has_d) send_data(d);
    chk(!dout_oe, "R12", {31'd0, dout_oe}, 32'd0);
    cs_dn();
    cs_up();
    if (act) chk(dout_oe && !dout_val, "R9", {30'd0, dout_oe, dout_val}, 32'h2);
    else     chk(!dout_oe, "R8", {31'd0, dout_oe}, 32'd0);
    tick(PROG + 16);
    if (act) chk(dout_oe && dout_val, "R9", {30'd0, dout_oe, dout_val}, 32'h3);
    cs_dn();
    chk(!dout_oe, "R9", {31'd0, dout_oe}, 32'd0);
    if (act) model_wr(b, has_d ? d : 16'hFFFF, all);
  endtask

  task automatic wr(input int b, input logic [15:0] d, input string tag);
    prog_op(2'b01, mk_field(b), b, d, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int n, b, sel;
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int w = 0; w < 128; w++) ref16[w] = 16'hFFFF;
    wen_ref = 1'b0;
    rst_n = 1'b0; cs = 1'b0; sck = 1'b0; din = 1'b0; org = 1'b1;
    tick(5); rst_n = 1'b1; tick(5);

    chk(!dout_oe, "R1", {31'd0, dout_oe}, 32'd0);
    read_words(0, 1, "R1");
    wr(3, 16'h1234, "R8");                       // R1: writes locked after reset
    read_words(3, 1, "R1");

    set_wen(1'b1);
    wr(5, 16'hA5C3, "R5");
    read_words(5, 1, "R2");
    prog_op(2'b01, 9'h089, 9, 16'h0F0F, 1'b0, 1'b1, "R2");   // field top bit set
    read_words(9, 1, "R2");
    prog_op(2'b11, mk_field(5), 5, 16'h0, 1'b0, 1'b0, "R6");
    read_words(5, 1, "R6");

    wr(127, 16'h1111, "R5"); wr(0, 16'h2222, "R5"); wr(126, 16'h3333, "R5");
    read_words(126, 3, "R3");

    // R13: program length measured from chip-select fall
    cs_up(); send_cmd(2'b01, mk_field(40)); send_data(16'hC0DE);
    cs = 1'b0; din = 1'b0; tick(6); cs = 1'b1; n = 6;
    while (!(dout_oe && dout_val) && n < PROG + 100) begin tick(1); n++; end
    chk(n >= PROG && n <= PROG + 12, "R13", n, PROG);
    cs_dn(); model_wr(40, 16'hC0DE, 1'b0);
    read_words(40, 1, "R13");

    // R10: second instruction during a program cycle
    cs_up(); send_cmd(2'b01, mk_field(20)); send_data(16'hBEEF); cs_dn();
    cs_up(); send_cmd(2'b01, mk_field(21)); send_data(16'hDEAD); cs_dn();
    tick(PROG + 20);
    model_wr(20, 16'hBEEF, 1'b0);
    read_words(20, 2, "R10");

    // R11: aborted instructions
    cs_up(); send_cmd(2'b01, mk_field(30)); sk_pulse(1'b0); sk_pulse(1'b1); cs_dn();
    chk(!dout_oe, "R11", {31'd0, dout_oe}, 32'd0);
    cs_up(); sk_pulse(1'b1); sk_pulse(1'b1); sk_pulse(1'b1); sk_pulse(1'b0); cs_dn();
    read_words(30, 1, "R11");

    set_wen(1'b0);
    wr(50, 16'h5555, "R8");
    read_words(50, 1, "R8");
    set_wen(1'b1);
    prog_op(2'b00, mk_ext(2'b01), 0, 16'h5AA5, 1'b1, 1'b1, "R7");
    read_words(0, 2, "R7"); read_words(77, 1, "R7");
    prog_op(2'b00, mk_ext(2'b10), 0, 16'h0, 1'b1, 1'b0, "R7");
    read_words(100, 2, "R7");

    org = 1'b0; tick(4);
    wr(11, 16'h005A, "R4"); wr(10, 16'h0011, "R4"); wr(255, 16'h0077, "R4");
    read_words(10, 2, "R4");
    read_words(254, 3, "R4");
    org = 1'b1; tick(4);
    read_words(5, 1, "R4");

    for (int it = 0; it < 60; it++) begin
      org = 1'($urandom); tick(4);
      b = int'($urandom % 256);
      d = 16'($urandom);
      sel = int'($urandom % 8);
      if (sel < 3)      read_words(b, 1 + int'($urandom % 2), org ? "R2" : "R4");
      else if (sel < 5) wr(b, d, "R5");
      else if (sel < 6) prog_op(2'b11, mk_field(b), b, 16'h0, 1'b0, 1'b0, "R6");
      else              set_wen(($urandom % 4) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule